// File: doc/BRIEF.md
# Rate-Half Convolutional Encoder with Zero-Tail Termination

This block turns a stream of information bits into coded symbols of two bits each, one symbol for every input bit. Each symbol is formed from the current bit and the three bits that came before it, which sit in a small history register. Two fixed tap masks select which of those four bits enter each modulo-2 sum, so the code has constraint length four.

Data arrives over a valid/ready bit interface. The first bit of a frame comes with a start strobe. Once the block has taken a fixed number of data bits, it inserts three zero bits of its own. During that time it holds its ready output low. These tail bits drive the history register back to all zeros, so the decoder at the far end sees a path that ends in the zero state. Symbols leave one cycle after the bit that forms them, with a valid qualifier and a flag on the final tail symbol of the frame.

Top module: `conv_enc_top`

## Requirements
- R1: The upper bit of out_sym (bit 1) is the modulo-2 sum of the current bit and the three previous bits: the newest, the middle and the oldest.
- R2: The lower bit of out_sym (bit 0) is the modulo-2 sum of the current bit, the newest previous bit and the oldest previous bit. The middle previous bit does not contribute. Data 1011 with its tail gives symbols 11 11 01 11 01 01 11, and data 0001 gives 00 00 00 11 11 10 11.
- R3: Each accepted bit (in_valid and in_ready both high on a rising edge) produces exactly one symbol with out_valid high on the following cycle. Each inserted tail bit also produces exactly one such symbol.
- R4: After FRAME_LEN accepted data bits, three zero tail bits are encoded automatically. A frame therefore yields FRAME_LEN+3 symbols.
- R5: in_ready is low for exactly the three cycles in which tail bits are encoded, and high otherwise.
- R6: out_last is high together with the final tail symbol of a frame and low on every other cycle.
- R7: The history register is treated as zero for the first bit of a frame and holds zero after the final tail bit. Back-to-back frames therefore encode independently of each other.
- R8: Bits offered while no frame is open and without in_start are dropped and produce no symbol.
- R9: in_start asserted with a bit inside an open frame is ignored. The frame neither restarts nor lengthens.
- R10: Cycles with in_valid low inside a frame produce no symbol and do not disturb the encoding of later bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bit qualifier |
| in_ready | output | 1 | Block can take a bit this cycle |
| in_bit | input | 1 | Information bit |
| in_start | input | 1 | Marks the first bit of a frame |
| out_valid | output | 1 | Symbol qualifier |
| out_sym | output | 2 | Coded symbol, first code bit in bit 1 |
| out_last | output | 1 | Final tail symbol of the frame |

## Verification
The hardest case to reach is a stray in_start that arrives in the middle of an open frame. Only the frame counter can tell a restart from a continuation, and a restart changes nothing visible until the tail comes out late. The bench raises in_start on the second data bit of a frame. It then compares the full symbol count and the position of the last flag against a frame whose length never changed. A separate scenario mixes idle gaps into a frame, to show that the counter and the history register both freeze while in_valid is low.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_TAIL = 2'd2
  } phase_t;

  // Modulo-2 sum of the window bits selected by a tap mask (up to 8 taps).
  function automatic logic tap_parity(input logic [7:0] win, input logic [7:0] taps);
    return ^(win & taps);
  endfunction

endpackage

// File: rtl/conv_enc_ctrl.sv
module conv_enc_ctrl
  import conv_enc_pkg::*;
#(
  parameter int FRAME_LEN = 4,
  parameter int MEM       = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_start,
  output logic in_ready,
  output logic shift_en,
  output logic frame_open,
  output logic tail_active,
  output logic tail_final
);

  localparam int CMAX = (FRAME_LEN > MEM) ? FRAME_LEN : MEM;
  localparam int CW   = $clog2(CMAX + 1);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic          fire;
  logic          take_data;
  logic          data_done;

  assign tail_active = (phase_q == PH_TAIL);
  assign in_ready    = !tail_active;
  assign fire        = in_valid && in_ready;
  assign frame_open  = fire && (phase_q == PH_IDLE) && in_start;
  assign take_data   = fire && (phase_q == PH_DATA);
  assign shift_en    = frame_open || take_data || tail_active;
  assign tail_final  = tail_active && (cnt_q == CW'(MEM - 1));
  assign data_done   = (cnt_q == CW'(FRAME_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (frame_open) begin
          if (FRAME_LEN == 1) begin
            phase_q <= PH_TAIL;
            cnt_q   <= '0;
          end else begin
            phase_q <= PH_DATA;
            cnt_q   <= CW'(1);
          end
        end
        PH_DATA: if (take_data) begin
          if (data_done) begin
            phase_q <= PH_TAIL;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        PH_TAIL: begin
          if (tail_final) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/conv_enc_shreg.sv
module conv_enc_shreg #(
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         clear,
  input  logic         new_bit,
  output logic [K-1:0] window,
  output logic [K-2:0] state_q
);

  logic [K-2:0] hist;

  // Newest previous bit sits in the top position of the history.
  assign hist   = clear ? '0 : state_q;
  assign window = {new_bit, hist};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (shift_en) begin
      state_q <= window[K-1:1];
    end
  end

endmodule

// File: rtl/conv_enc_top.sv
module conv_enc_top
  import conv_enc_pkg::*;
#(
  parameter int           FRAME_LEN = 4,
  parameter int           K         = 4,
  parameter logic [K-1:0] G_UPPER   = 4'b1111,
  parameter logic [K-1:0] G_LOWER   = 4'b1101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_bit,
  input  logic       in_start,
  output logic       out_valid,
  output logic [1:0] out_sym,
  output logic       out_last
);

  localparam int MEM = K - 1;

  logic           shift_en;
  logic           frame_open;
  logic           tail_active;
  logic           tail_final;
  logic           feed_bit;
  logic [K-1:0]   window;
  logic [MEM-1:0] state_q;
  logic [1:0]     sym_next;

  conv_enc_ctrl #(.FRAME_LEN(FRAME_LEN), .MEM(MEM)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_start   (in_start),
    .in_ready   (in_ready),
    .shift_en   (shift_en),
    .frame_open (frame_open),
    .tail_active(tail_active),
    .tail_final (tail_final)
  );

  assign feed_bit = tail_active ? 1'b0 : in_bit;

  conv_enc_shreg #(.K(K)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .clear   (frame_open),
    .new_bit (feed_bit),
    .window  (window),
    .state_q (state_q)
  );

  assign sym_next[1] = tap_parity(8'(window), 8'(G_UPPER));
  assign sym_next[0] = tap_parity(8'(window), 8'(G_LOWER));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= shift_en;
      out_sym   <= shift_en ? sym_next : '0;
      out_last  <= tail_final;
    end
  end

endmodule

// File: rtl/conv_enc_chk.sv
module conv_enc_chk #(
  parameter int MEM = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_last,
  input logic           tail_active,
  input logic [MEM-1:0] state_q
);

  AST_TAIL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    tail_active |-> !in_ready) else $error("tail with ready high"); // R5

  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid) else $error("last without valid"); // R6

  AST_FLUSHED_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (state_q == '0)) else $error("history not flushed"); // R7

  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> in_ready) else $error("ready not restored"); // R5

  AST_TAIL_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    tail_active |=> out_valid) else $error("tail bit without symbol"); // R4

endmodule

bind conv_enc_top conv_enc_chk #(.MEM(MEM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_last   (out_last),
  .tail_active(tail_active),
  .state_q    (state_q)
);

// File: tb/sim_conv_enc_top.sv
`timescale 1ns/1ps
module sim_conv_enc_top;

  localparam int L = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       in_start = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic [1:0] out_sym;
  logic       out_last;

  int n_chk = 0;
  int n_fail = 0;
  int cap_n = 0;
  logic [1:0] cap_sym [64];
  logic       cap_last[64];

  always #4 clk = ~clk;

  conv_enc_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_start(in_start), .out_valid(out_valid),
    .out_sym(out_sym), .out_last(out_last)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && cap_n < 64) begin
      cap_sym[cap_n]  = out_sym;
      cap_last[cap_n] = out_last;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference: u1 = new bit, a = newest past, b = middle past, c = oldest past.
  function automatic logic [1:0] ref_sym(input logic u1, input logic a, input logic b, input logic c);
    logic first, second;
    first  = u1 ^ a ^ b ^ c;
    second = u1 ^ a ^ c;
    return {first, second};
  endfunction

  // Drive a frame of L bits; gap_after lists per-bit idle cycles; start_at marks a stray start.
  task automatic send_frame(input logic [L-1:0] data, input int gap, input int stray_idx);
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_bit   = data[L-1-i];
      in_start = (i == 0) || (i == stray_idx);
      if (i == L - 1) begin
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0;
        for (int t = 0; t < 3; t++) begin
          chk(in_ready == 1'b0, "R5", int'(in_ready), 0);
          @(negedge clk);
        end
        chk(in_ready == 1'b1, "R5", int'(in_ready), 1);
      end else begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0; in_start = 1'b0; in_bit = ~in_bit;
        end
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frame(input logic [L-1:0] data, input int base, input string tag);
    logic a, b, c, u;
    logic [1:0] e;
    a = 0; b = 0; c = 0;
    chk(cap_n - base == L + 3, "R4", cap_n - base, L + 3);
    for (int i = 0; i < L + 3; i++) begin
      u = (i < L) ? data[L-1-i] : 1'b0;
      e = ref_sym(u, a, b, c);
      c = b; b = a; a = u;
      chk(cap_sym[base+i] == e, tag, int'(cap_sym[base+i]), int'(e));
      chk(cap_last[base+i] == (i == L + 2), "R6", int'(cap_last[base+i]), int'(i == L + 2));
    end
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R3 reset valid", int'(out_valid), 0);
    chk(out_last == 1'b0, "R6 reset last", int'(out_last), 0);
    chk(in_ready == 1'b1, "R5 reset ready", int'(in_ready), 1);
  endtask

  task automatic t_basic(input logic [L-1:0] d, input string tag);
    int base;
    base = cap_n;
    send_frame(d, 0, -1);
    check_frame(d, base, tag);
  endtask

  task automatic t_known_vectors();
    int base;
    logic [13:0] e1, e2;
    e1 = 14'b11_11_01_11_01_01_11;
    e2 = 14'b00_00_00_11_11_10_11;
    base = cap_n;
    send_frame(4'b1011, 0, -1);
    for (int i = 0; i < 7; i++)
      chk(cap_sym[base+i] == e1[13-2*i -: 2], "R2 1011", int'(cap_sym[base+i]), int'(e1[13-2*i -: 2]));
    base = cap_n;
    send_frame(4'b0001, 0, -1);
    for (int i = 0; i < 7; i++)
      chk(cap_sym[base+i] == e2[13-2*i -: 2], "R2 0001", int'(cap_sym[base+i]), int'(e2[13-2*i -: 2]));
  endtask

  task automatic t_idle_drop();
    int base;
    base = cap_n;
    @(negedge clk);
    in_valid = 1'b1; in_start = 1'b0; in_bit = 1'b1;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(cap_n == base, "R8", cap_n - base, 0);
    t_basic(4'b0110, "R8 after drop");
  endtask

  task automatic t_stray_start();
    int base;
    base = cap_n;
    send_frame(4'b1101, 0, 1);
    check_frame(4'b1101, base, "R9");
  endtask

  task automatic t_gaps();
    int base;
    base = cap_n;
    send_frame(4'b1001, 2, -1);
    check_frame(4'b1001, base, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_known_vectors();                 // R1 R2 R3
    t_basic(4'b1111, "R1 1111");
    t_basic(4'b1011, "R7 back-to-back");
    t_basic(4'b0100, "R3 0100");
    t_idle_drop();
    t_stray_start();
    t_gaps();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule